// File: doc/BRIEF.md
# Complex Givens Rotation Parameter Unit

This block derives everything needed to rotate a complex 2-vector [a; b] so that its lower element vanishes and its upper element becomes real. Each operand arrives as a pair of 16-bit signed fixed-point values (real and imaginary). The rotation is split into real-valued steps. Two vectoring CORDIC engines run side by side and strip the phase from a and from b, giving each operand's angle and magnitude. A third vectoring CORDIC then takes the two magnitudes as a real vector. It returns the real rotation angle and the norm of the vector.

A caller raises `start_i` for one cycle with the operands on the inputs. The block is busy for two CORDIC passes. It then pulses `done_o` with both phases, their difference, the real rotation angle and the norm, all held until the next result. Each engine runs 12 micro-rotations by default and removes the CORDIC gain from its magnitude by a constant multiply. Inputs on an axis, or in the left half plane, are first turned by a quarter turn so that vectoring converges.

Angles use a binary format. A 16-bit two's complement word covers one full turn, the value 16384 (0x4000) is +90 degrees, and 32768 (0x8000) is 180 degrees. Sums and differences therefore wrap correctly on the circle.

Top module: `cgivens_param_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and every result output is 0.
- R2: `phase_a_o` and `phase_b_o` equal atan2(im, re) of a and of b in the 16-bit angle format, where 16384 is +90 degrees and a full turn is 65536, and values wrap modulo 65536. The tolerance is 12 counts plus the error caused by the operand's size.
- R3: `theta_o` equals atan2(|b|, |a|) in the same format, which lies between 0 and 16384.
- R4: `r_o` equals sqrt(|a|^2 + |b|^2), an unsigned 17-bit integer with the same scale as the inputs, to within 6 + r/256.
- R5: `dphi_o` equals `phase_b_o - phase_a_o` modulo 65536 exactly.
- R6: When a and b are both zero, `phase_a_o`, `phase_b_o`, `dphi_o`, `theta_o` and `r_o` are exactly 0. An operand that is zero on its own reports phase 0.
- R7: An operand with zero real part and nonzero imaginary part reports phase +16384 (imag > 0) or 49152 (imag < 0). A negative real operand with zero imaginary part reports 32768. Both allow the R2 tolerance.
- R8: `done_o` is a one-cycle pulse on the 2*ITER+3rd rising edge after the edge that accepts `start_i` (27 with ITER=12). `busy_o` is 1 from the accepting edge until the edge that raises `done_o`.
- R9: A `start_i` seen while `busy_o` is 1 is ignored. The running operation keeps its latency and its operands, and no extra `done_o` follows.
- R10: A `start_i` seen in the cycle where `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation with the present operands (accepted when not busy) |
| a_re_i | input | 16 | Real part of a, signed |
| a_im_i | input | 16 | Imaginary part of a, signed |
| b_re_i | input | 16 | Real part of b, signed |
| b_im_i | input | 16 | Imaginary part of b, signed |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| phase_a_o | output | 16 | Phase of a, binary angle |
| phase_b_o | output | 16 | Phase of b, binary angle |
| dphi_o | output | 16 | phase_b_o minus phase_a_o, binary angle |
| theta_o | output | 16 | Real rotation angle atan2(\|b\|, \|a\|), binary angle |
| r_o | output | 17 | Norm sqrt(\|a\|^2 + \|b\|^2), unsigned |

## Verification
Result delivery and the acceptance of a new operation can fall in the same cycle. This happens when `start_i` is high while `done_o` pulses. The bench provokes it by issuing every operation in the cycle where the previous `done_o` is observed. It judges the outcome by two things: the previous results must remain correct, and the new operation must show the full 2*ITER+3 latency with values matching its own operands. A start given mid-operation with different operands is also injected. It must change neither the latency nor the values, and must not produce a second pulse.

// File: rtl/cgv_pkg.sv
package cgv_pkg;
  localparam int ANG_W     = 16;
  localparam int KINV_FRAC = 16;
  localparam int KINV      = 39797;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_PHASE  = 2'd1,
    S_LAUNCH = 2'd2,
    S_ROT    = 2'd3
  } cgv_state_t;

  // atan(2^-i) in binary angle units (65536 per turn)
  function automatic logic [ANG_W-1:0] cgv_atan_step(input int unsigned idx);
    case (idx)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/cgv_prerotate.sv
module cgv_prerotate
  import cgv_pkg::*;
#(
  parameter int IW = 20
) (
  input  logic signed [IW-1:0]    x_i,
  input  logic signed [IW-1:0]    y_i,
  output logic signed [IW-1:0]    x_o,
  output logic signed [IW-1:0]    y_o,
  output logic        [ANG_W-1:0] z_o,
  output logic                    zero_o
);
  localparam logic [ANG_W-1:0] QTR = ANG_W'(1) << (ANG_W - 2);

  always_comb begin
    zero_o = (x_i == '0) && (y_i == '0);
    x_o    = x_i;
    y_o    = y_i;
    z_o    = '0;
    if (!zero_o && (x_i <= 0)) begin
      if (y_i >= 0) begin
        // turn by -90 degrees, credit +90
        x_o = y_i;
        y_o = -x_i;
        z_o = QTR;
      end else begin
        // turn by +90 degrees, credit -90
        x_o = -y_i;
        y_o = x_i;
        z_o = -QTR;
      end
    end
  end
endmodule

// File: rtl/cgv_gain_scale.sv
module cgv_gain_scale
  import cgv_pkg::*;
#(
  parameter int IW    = 20,
  parameter int GUARD = 2,
  parameter int OW    = 17
) (
  input  logic signed [IW-1:0] x_i,
  output logic        [OW-1:0] m_o
);
  localparam int PW = IW + KINV_FRAC + 2;
  localparam int SH = KINV_FRAC + GUARD;
  localparam logic signed [PW-1:0] KCONST = PW'(KINV);
  localparam logic signed [PW-1:0] HALF   = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV   = PW'((64'd1 << OW) - 64'd1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shr;

  always_comb begin
    prod = PW'(x_i) * KCONST;
    shr  = (prod + HALF) >>> SH;
    if (shr < 0)         m_o = '0;
    else if (shr > MAXV) m_o = '1;
    else                 m_o = shr[OW-1:0];
  end
endmodule

// File: rtl/cgv_vec_engine.sv
module cgv_vec_engine
  import cgv_pkg::*;
#(
  parameter  int IN_W  = 16,
  parameter  int ITER  = 12,
  parameter  int GUARD = 2,
  localparam int IW    = IN_W + GUARD + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [IN_W-1:0]  y_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [IW-1:0]    x_o,
  output logic        [ANG_W-1:0] z_o
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  logic signed [IW-1:0]    xe, ye, xp, yp;
  logic signed [IW-1:0]    x_q, y_q, xs, ys;
  logic        [ANG_W-1:0] z0, z_q, step;
  logic                    zero_p, zero_q;
  logic        [CW-1:0]    cnt_q;

  assign xe = $signed(IW'(x_i)) <<< GUARD;
  assign ye = $signed(IW'(y_i)) <<< GUARD;

  cgv_prerotate #(.IW(IW)) u_pre (
    .x_i(xe), .y_i(ye), .x_o(xp), .y_o(yp), .z_o(z0), .zero_o(zero_p)
  );

  assign xs   = x_q >>> cnt_q;
  assign ys   = y_q >>> cnt_q;
  assign step = cgv_atan_step(32'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      zero_q <= 1'b1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        x_q    <= xp;
        y_q    <= yp;
        z_q    <= z0;
        zero_q <= zero_p;
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (y_q >= 0) begin
          x_q <= x_q + ys;
          y_q <= y_q - xs;
          z_q <= z_q + step;
        end else begin
          x_q <= x_q - ys;
          y_q <= y_q + xs;
          z_q <= z_q - step;
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign x_o = x_q;
  assign z_o = zero_q ? '0 : z_q;

  // R8: micro-rotation counter stays inside the pass
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q <= LAST));

  // R8: completion follows a busy cycle and ends it
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  // R7: the loaded vector lies in the right half plane after the quarter turn
  a_r7_right_half: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (x_q >= 0));
endmodule

// File: rtl/cgivens_param_unit.sv
module cgivens_param_unit
  import cgv_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ITER  = 12,
  parameter int GUARD = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [ANG_W-1:0]     phase_a_o,
  output logic [ANG_W-1:0]     phase_b_o,
  output logic [ANG_W-1:0]     dphi_o,
  output logic [ANG_W-1:0]     theta_o,
  output logic [DW:0]          r_o
);
  localparam int MW  = DW + 1;
  localparam int RIN = MW + 1;
  localparam int IWP = DW + GUARD + 2;
  localparam int IWR = RIN + GUARD + 2;
  localparam logic [ANG_W-1:0] QTR = ANG_W'(1) << (ANG_W - 2);

  cgv_state_t state_q;

  logic                    go_ph, go_r;
  logic                    busy_a, busy_b, busy_r;
  logic                    done_a, done_b, done_r;
  logic signed [IWP-1:0]   xa, xb;
  logic signed [IWR-1:0]   xr;
  logic        [ANG_W-1:0] za, zb, zr;
  logic        [MW-1:0]    ma, mb, mr;
  logic        [MW-1:0]    ma_q, mb_q;
  logic        [ANG_W-1:0] pa_q, pb_q;
  logic signed [RIN-1:0]   rx_in, ry_in;

  assign go_ph = start_i && (state_q == S_IDLE);
  assign go_r  = (state_q == S_LAUNCH);
  assign rx_in = $signed({1'b0, ma_q});
  assign ry_in = $signed({1'b0, mb_q});

  cgv_vec_engine #(.IN_W(DW), .ITER(ITER), .GUARD(GUARD)) u_eng_a (
    .clk(clk), .rst(rst), .start_i(go_ph), .x_i(a_re_i), .y_i(a_im_i),
    .busy_o(busy_a), .done_o(done_a), .x_o(xa), .z_o(za)
  );

  cgv_vec_engine #(.IN_W(DW), .ITER(ITER), .GUARD(GUARD)) u_eng_b (
    .clk(clk), .rst(rst), .start_i(go_ph), .x_i(b_re_i), .y_i(b_im_i),
    .busy_o(busy_b), .done_o(done_b), .x_o(xb), .z_o(zb)
  );

  cgv_vec_engine #(.IN_W(RIN), .ITER(ITER), .GUARD(GUARD)) u_eng_r (
    .clk(clk), .rst(rst), .start_i(go_r), .x_i(rx_in), .y_i(ry_in),
    .busy_o(busy_r), .done_o(done_r), .x_o(xr), .z_o(zr)
  );

  cgv_gain_scale #(.IW(IWP), .GUARD(GUARD), .OW(MW)) u_scale_a (.x_i(xa), .m_o(ma));
  cgv_gain_scale #(.IW(IWP), .GUARD(GUARD), .OW(MW)) u_scale_b (.x_i(xb), .m_o(mb));
  cgv_gain_scale #(.IW(IWR), .GUARD(GUARD), .OW(MW)) u_scale_r (.x_i(xr), .m_o(mr));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ma_q      <= '0;
      mb_q      <= '0;
      pa_q      <= '0;
      pb_q      <= '0;
      done_o    <= 1'b0;
      phase_a_o <= '0;
      phase_b_o <= '0;
      dphi_o    <= '0;
      theta_o   <= '0;
      r_o       <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (go_ph) state_q <= S_PHASE;
        end
        S_PHASE: begin
          if (done_a && done_b) begin
            ma_q    <= ma;
            mb_q    <= mb;
            pa_q    <= za;
            pb_q    <= zb;
            state_q <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          state_q <= S_ROT;
        end
        S_ROT: begin
          if (done_r) begin
            phase_a_o <= pa_q;
            phase_b_o <= pb_q;
            dphi_o    <= pb_q - pa_q;
            theta_o   <= zr;
            r_o       <= mr;
            done_o    <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // R8: the two phase engines run in lockstep
  a_r8_engines_lockstep: assert property (@(posedge clk) disable iff (rst)
    (done_a == done_b) && (busy_a == busy_b));

  // R9: no engine is running while the controller is idle
  a_r9_idle_engines: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !(busy_a || busy_b || busy_r));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: completion ends a busy period
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  // R9: a busy period only opens on a start request
  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R3: real rotation angle stays within the first quadrant (small CORDIC slack)
  a_r3_theta_quadrant: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (($signed(theta_o) >= -16) && ($signed(theta_o) <= $signed(QTR + 16'd16))));
endmodule

// File: tb/tb_cgivens_param_unit.sv
module tb_cgivens_param_unit;
  localparam int DW   = 16;
  localparam int ITER = 12;
  localparam int LAT  = 2 * ITER + 3;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic signed [DW-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic busy_o, done_o;
  logic [15:0] phase_a_o, phase_b_o, dphi_o, theta_o;
  logic [DW:0] r_o;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  cgivens_param_unit #(.DW(DW), .ITER(ITER), .GUARD(2)) dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .busy_o(busy_o), .done_o(done_o),
    .phase_a_o(phase_a_o), .phase_b_o(phase_b_o), .dphi_o(dphi_o),
    .theta_o(theta_o), .r_o(r_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real vmag(input int re, input int im);
    return $sqrt(real'(re) * real'(re) + real'(im) * real'(im));
  endfunction

  function automatic int to_ang(input real rad);
    int v;
    v = int'(rad * 32768.0 / PI);
    return v & 32'hFFFF;
  endfunction

  function automatic int exp_phase(input int re, input int im);
    if (re == 0 && im == 0) return 0;
    return to_ang($atan2(real'(im), real'(re)));
  endfunction

  function automatic int ang_dist(input logic [15:0] act, input int exp);
    logic signed [15:0] d;
    d = act - 16'(exp);
    return (d < 0) ? -int'(d) : int'(d);
  endfunction

  function automatic int ang_tol(input real m, input real k);
    if (m < 1.0) return 65536;
    return 12 + int'(10430.0 * k / m);
  endfunction

  // issue one operation; caller is at a negedge; returns at the negedge after done
  task automatic run_op(input int ar, input int ai, input int br, input int bi,
                        input int inject, input string tag);
    int n;
    real ma, mb, mr;
    int ea, eb, et;
    a_re_i = 16'(ar); a_im_i = 16'(ai); b_re_i = 16'(br); b_im_i = 16'(bi);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    a_re_i = 16'($urandom); a_im_i = 16'($urandom);
    b_re_i = 16'($urandom); b_im_i = 16'($urandom);
    check(busy_o == 1'b1, "R8", {tag, " busy after accept"}, busy_o, 1);
    n = 0;
    while (!done_o && n < 100) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      start_i = 1'b0;
      if (n == inject) begin
        start_i = 1'b1;
        a_re_i = 16'($urandom); a_im_i = 16'($urandom);
        b_re_i = 16'($urandom); b_im_i = 16'($urandom);
      end
    end
    start_i = 1'b0;
    check(n == LAT, "R8 R10", {tag, " latency"}, n, LAT);
    check(busy_o == 1'b0, "R8", {tag, " idle at done"}, busy_o, 0);
    ma = vmag(ar, ai);
    mb = vmag(br, bi);
    mr = $sqrt(ma * ma + mb * mb);
    ea = exp_phase(ar, ai);
    eb = exp_phase(br, bi);
    et = (ma == 0.0 && mb == 0.0) ? 0 : to_ang($atan2(mb, ma));
    check(ang_dist(phase_a_o, ea) <= ang_tol(ma, 3.0), "R2", {tag, " phase a"}, phase_a_o, ea);
    check(ang_dist(phase_b_o, eb) <= ang_tol(mb, 3.0), "R2", {tag, " phase b"}, phase_b_o, eb);
    check(ang_dist(theta_o, et) <= ang_tol((ma > mb) ? ma : mb, 6.0), "R3", {tag, " theta"}, theta_o, et);
    check((real'(r_o) - mr <= 6.0 + mr / 256.0) && (mr - real'(r_o) <= 6.0 + mr / 256.0),
          "R4", {tag, " norm"}, r_o, int'(mr));
    check(dphi_o == 16'(phase_b_o - phase_a_o), "R5", {tag, " phase difference"},
          dphi_o, 16'(phase_b_o - phase_a_o));
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R1", "control after reset", {busy_o, done_o}, 0);
    check(phase_a_o == 0 && phase_b_o == 0 && dphi_o == 0, "R1", "phases after reset",
          phase_a_o | phase_b_o | dphi_o, 0);
    check(theta_o == 0 && r_o == 0, "R1", "theta and norm after reset", theta_o | r_o, 0);

    // R6: both operands zero give exact zeros
    run_op(0, 0, 0, 0, 0, "R6 zero pair");
    check(phase_a_o == 0 && phase_b_o == 0 && dphi_o == 0 && theta_o == 0 && r_o == 0,
          "R6", "all-zero result", phase_a_o | phase_b_o | theta_o | r_o, 0);

    // R7: axis operands
    run_op(0, 1000, 0, -1000, 0, "R7 imaginary axis");
    check(ang_dist(phase_a_o, 16384) <= 12, "R7", "phase +90", phase_a_o, 16384);
    check(ang_dist(phase_b_o, 49152) <= 12, "R7", "phase -90", phase_b_o, 49152);
    run_op(-1000, 0, 1000, 0, 0, "R7 real axis");
    check(ang_dist(phase_a_o, 32768) <= 12, "R7", "phase 180", phase_a_o, 32768);
    check(ang_dist(phase_b_o, 0) <= 12, "R7", "phase 0", phase_b_o, 0);

    // R6: one operand zero
    run_op(12000, -7000, 0, 0, 0, "R6 b zero");
    check(phase_b_o == 0, "R6", "zero operand phase", phase_b_o, 0);
    check(ang_dist(theta_o, 0) <= 12, "R3", "theta with b zero", theta_o, 0);
    run_op(0, 0, -5000, 9000, 0, "R6 a zero");
    check(phase_a_o == 0, "R6", "zero operand phase", phase_a_o, 0);
    check(ang_dist(theta_o, 16384) <= 12, "R3", "theta with a zero", theta_o, 16384);

    // extremes
    run_op(-32768, -32768, 32767, -32768, 0, "R4 full scale");
    run_op(32767, 32767, 32767, 32767, 0, "R4 max norm");

    // R9: mid-operation start must be ignored
    run_op(20000, 3000, -4000, 15000, 5, "R9 early inject");
    run_op(-9000, -9000, 100, 30000, LAT - 1, "R9 late inject");
    repeat (LAT + 4) begin
      @(negedge clk);
      check(done_o == 0 && busy_o == 0, "R9", "no extra operation", {busy_o, done_o}, 0);
    end

    // R10: back-to-back random operations, each started in the done cycle
    for (int i = 0; i < 150; i++) begin
      int ar, ai, br, bi, mode;
      mode = int'($urandom_range(0, 3));
      if (mode == 0) begin
        ar = int'($urandom_range(0, 600)) - 300; ai = int'($urandom_range(0, 600)) - 300;
        br = int'($urandom_range(0, 600)) - 300; bi = int'($urandom_range(0, 600)) - 300;
      end else begin
        ar = int'($urandom_range(0, 65535)) - 32768; ai = int'($urandom_range(0, 65535)) - 32768;
        br = int'($urandom_range(0, 65535)) - 32768; bi = int'($urandom_range(0, 65535)) - 32768;
      end
      if (mode == 3) begin
        if ($urandom_range(0, 1) == 0) ar = 0; else bi = 0;
      end
      run_op(ar, ai, br, bi, 0, "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule